// File: doc/BRIEF.md
# Asynchronous Strobe Bus Register Slave

This block lets a CPU with an asynchronous, strobe-timed bus read and write a small file of 8-bit registers. The CPU puts a 9-bit address on the bus and pulses the active-low address strobe. The address is captured when that strobe returns high. The CPU then sets the read/write select and lowers the active-low data strobe. On a write the block stores the byte from the bidirectional data bus into the addressed register. On a read it drives the addressed register onto the data bus. In both cases it then lowers an acknowledge line, and the CPU waits for that line before it ends the cycle.

All bus inputs are asynchronous to the internal clock. Each one passes through a synchronizer chain before use, and every strobe edge is found in the internal clock domain. The acknowledge is released after the CPU raises the data strobe again. The register count, the synchronizer depth and the acknowledge delay are parameters. Addresses beyond the last register are decoded in full: they read as zero, and writes to them are dropped.

Top module: `async_strobe_bus_slave`

## Requirements
- R1: After reset, `dtack_n` is high and every register reads back as 0x00.
- R2: The address is taken from `bus_addr` at the rising edge of `as_n`. A change of `bus_addr` after that edge has no effect on the current cycle.
- R3: With `rw` low (write), the byte on `bus_data` is stored into the addressed register once the falling edge of `ds_n` is detected. This holds even if the strobe ends before acknowledge.
- R4: With `rw` high (read), `bus_data` carries the addressed register's value while `dtack_n` is low.
- R5: `dtack_n` falls exactly SYNC_STAGES+ACK_DELAY rising clock edges after `ds_n` falls, which is 4 edges with the defaults.
- R6: `dtack_n` rises exactly SYNC_STAGES+1 rising clock edges after `ds_n` rises, which is 3 edges with the defaults.
- R7: Addresses at or above NUM_REGS (default 16) are compared on all 9 bits. They read 0x00, and writes to them change no register. For example, 0x103 does not alias register 3.
- R8: The block drives `bus_data` only while the synchronized `ds_n` is low and the synchronized `rw` is high. At all other times the bus is released.
- R9: Even and odd addresses are separate registers and are each fully accessible.
- R10: If `ds_n` is low for fewer cycles than the acknowledge delay, `dtack_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 9 | Register address from the CPU |
| as_n | input | 1 | Address strobe, active low; the address is captured on its rising edge |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | High for a read, low for a write |
| bus_data | inout | 8 | Bidirectional data bus |
| dtack_n | output | 1 | Transfer acknowledge, active low |

## Verification
A corrupted latched address shows up at the next read as the wrong byte, or as zero from an unmapped slot. A write that aliases or goes astray shows up as a changed neighbour register on the following read-back. A fault in the acknowledge state machine shows within one to four clock edges of a strobe edge: `dtack_n` falls one cycle early or late, fails to release, or appears after an aborted strobe. Because each data check is taken in the acknowledge window, a register file fault is seen within the same bus cycle.

// File: rtl/bus_slave_pkg.sv
package bus_slave_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_COUNT = 2'd1,
      ST_ACK   = 2'd2
   } ack_state_t;
endpackage

// File: rtl/bsl_sync.sv
module bsl_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("bsl_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '1;
            else if (s == 0) stg[s] <= d;
            else stg[s] <= stg[(s > 0) ? s-1 : 0];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/bsl_ack_ctrl.sv
module bsl_ack_ctrl
   import bus_slave_pkg::*;
#(
   parameter int ACK_DELAY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ds_s,
   output logic ds_fall,
   output logic dtack_n
);
   localparam int CNT_W = (ACK_DELAY > 2) ? $clog2(ACK_DELAY) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACK_DELAY - 2);

   ack_state_t       state;
   logic             ds_prev;
   logic [CNT_W-1:0] cnt;

   generate
      if (ACK_DELAY < 2) begin : g_bad
         $error("ACK_DELAY must be at least 2");
      end
   endgenerate

   assign ds_fall = ds_prev & ~ds_s;
   assign dtack_n = (state != ST_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ds_prev <= 1'b1;
         cnt     <= '0;
      end else begin
         ds_prev <= ds_s;
         unique case (state)
            ST_IDLE: if (ds_fall) begin
               state <= ST_COUNT;
               cnt   <= CNT_LOAD;
            end
            ST_COUNT: begin
               if (ds_s) state <= ST_IDLE;
               else if (cnt == '0) state <= ST_ACK;
               else cnt <= cnt - 1'b1;
            end
            ST_ACK: if (ds_s) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACK && ds_s) |=> dtack_n);
   p_ack_after_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dtack_n) |-> ($past(state) == ST_COUNT && !$past(ds_s)));
   p_abort_no_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_COUNT && ds_s) |=> dtack_n);
endmodule

// File: rtl/bsl_regfile.sv
module bsl_regfile #(
   parameter int ADDR_W   = 9,
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

   logic [NUM_REGS-1:0][DATA_W-1:0] mem;

   generate
      if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad
         $error("NUM_REGS does not fit the address space");
      end
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem[i] <= '0;
            else if (wr_en && addr == ADDR_W'(i)) mem[i] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (addr == ADDR_W'(i)) rdata = mem[i];
      end
   end

   p_no_stray_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || {1'b0, addr} >= LIMIT) |=> $stable(mem));
endmodule

// File: rtl/async_strobe_bus_slave.sv
module async_strobe_bus_slave #(
   parameter int ADDR_W      = 9,
   parameter int DATA_W      = 8,
   parameter int NUM_REGS    = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ACK_DELAY   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              as_n,
   input  logic              ds_n,
   input  logic              rw,
   inout  wire  [DATA_W-1:0] bus_data,
   output logic              dtack_n
);
   localparam int SW = ADDR_W + DATA_W + 3;

   logic [ADDR_W-1:0] addr_s, lat_addr;
   logic [DATA_W-1:0] data_s, rdata;
   logic              as_s, ds_s, rw_s, as_prev, as_rise;
   logic              ds_fall, wr_en, drv_en;

   bsl_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({bus_addr, bus_data, as_n, ds_n, rw}),
      .q    ({addr_s, data_s, as_s, ds_s, rw_s})
   );

   assign as_rise = as_s & ~as_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         as_prev  <= 1'b1;
         lat_addr <= '0;
      end else begin
         as_prev <= as_s;
         if (as_rise) lat_addr <= addr_s;
      end
   end

   bsl_ack_ctrl #(.ACK_DELAY(ACK_DELAY)) u_ack (
      .clk    (clk),
      .rst_n  (rst_n),
      .ds_s   (ds_s),
      .ds_fall(ds_fall),
      .dtack_n(dtack_n)
   );

   assign wr_en = ds_fall & ~rw_s;

   bsl_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(wr_en),
      .addr (lat_addr),
      .wdata(data_s),
      .rdata(rdata)
   );

   assign drv_en   = rw_s & ~ds_s;
   assign bus_data = drv_en ? rdata : 'z;

   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !as_rise |=> $stable(lat_addr));
   p_drive_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dtack_n |-> (!ds_s || $past(!ds_s)));
   p_write_not_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !drv_en);
endmodule

// File: tb/test_async_strobe_bus_slave.sv
module test_async_strobe_bus_slave;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] bus_addr = '0;
   logic       as_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
   logic       tb_en = 1'b0;
   logic [7:0] tb_drv = '0;
   wire  [7:0] bus_data;
   logic       dtack_n;
   int         total = 0, bad = 0;
   logic [7:0] mdl [16];

   assign bus_data = tb_en ? tb_drv : 'z;

   always #2.5 clk = ~clk;

   async_strobe_bus_slave i_async_strobe_bus_slave (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .as_n(as_n),
      .ds_n(ds_n), .rw(rw), .bus_data(bus_data), .dtack_n(dtack_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic negs(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic latch_addr(input logic [8:0] a);
      @(negedge clk);
      bus_addr = a;
      as_n = 1'b0;
      negs(3);
      as_n = 1'b1;
      negs(4);
   endtask

   // One data-strobe cycle with timing checks (R5, R6); returns read data.
   task automatic strobe_cycle(input bit is_read, input logic [7:0] wd, output logic [7:0] rd);
      @(negedge clk);
      rw = is_read;
      tb_drv = wd;
      tb_en = !is_read;
      @(negedge clk);
      ds_n = 1'b0;
      negs(3);
      chk(dtack_n == 1'b1, "R5 early", dtack_n, 1);
      negs(1);
      chk(dtack_n == 1'b0, "R5 on time", dtack_n, 0);
      rd = bus_data;
      ds_n = 1'b1;
      negs(2);
      chk(dtack_n == 1'b0, "R6 held", dtack_n, 0);
      negs(1);
      chk(dtack_n == 1'b1, "R6 release", dtack_n, 1);
      tb_en = 1'b0;
      rw = 1'b1;
      negs(2);
   endtask

   task automatic wr(input logic [8:0] a, input logic [7:0] d);
      logic [7:0] dummy;
      latch_addr(a);
      strobe_cycle(1'b0, d, dummy);
   endtask

   task automatic rd_chk(input logic [8:0] a, input logic [7:0] exp, input string req);
      logic [7:0] got;
      latch_addr(a);
      strobe_cycle(1'b1, 8'h00, got);
      chk(got == exp, req, got, exp);
   endtask

   task automatic t_reset();
      chk(dtack_n == 1'b1, "R1 dtack", dtack_n, 1);
      rd_chk(9'd0, 8'h00, "R1 reg0");
      rd_chk(9'd5, 8'h00, "R1 reg5");
      rd_chk(9'd15, 8'h00, "R1 reg15");
   endtask

   task automatic t_even_odd();
      wr(9'd3, 8'hA5); mdl[3] = 8'hA5;
      wr(9'd4, 8'h5A); mdl[4] = 8'h5A;
      rd_chk(9'd3, 8'hA5, "R9 odd");
      rd_chk(9'd4, 8'h5A, "R9 even");
   endtask

   task automatic t_fill_all();
      for (int i = 0; i < 16; i++) begin
         mdl[i] = 8'(i * 17) ^ 8'h3C;
         wr(9'(i), mdl[i]);
      end
      for (int i = 0; i < 16; i++) rd_chk(9'(i), mdl[i], "R3 R4 R8 fill");
   endtask

   task automatic t_addr_latch();
      logic [7:0] dummy;
      latch_addr(9'd8);
      bus_addr = 9'd9;
      negs(3);
      strobe_cycle(1'b0, 8'h88, dummy);
      mdl[8] = 8'h88;
      rd_chk(9'd8, 8'h88, "R2 latched");
      rd_chk(9'd9, mdl[9], "R2 other");
   endtask

   task automatic t_unmapped();
      wr(9'h103, 8'hEE);
      wr(9'h1FF, 8'h11);
      rd_chk(9'h103, 8'h00, "R7 read zero");
      rd_chk(9'h1FF, 8'h00, "R7 read zero top");
      rd_chk(9'd3, mdl[3], "R7 no alias");
      rd_chk(9'd15, mdl[15], "R7 no alias top");
   endtask

   task automatic t_abort();
      bit seen = 1'b0;
      latch_addr(9'd2);
      @(negedge clk);
      rw = 1'b0; tb_drv = 8'h42; tb_en = 1'b1;
      @(negedge clk);
      ds_n = 1'b0;
      @(negedge clk);
      ds_n = 1'b1;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (!dtack_n) seen = 1'b1;
      end
      chk(!seen, "R10 no ack", seen, 0);
      tb_en = 1'b0; rw = 1'b1;
      mdl[2] = 8'h42;
      rd_chk(9'd2, 8'h42, "R3 short strobe write");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
      negs(3);
      rst_n = 1'b1;
      negs(3);
      t_reset();
      t_even_odd();
      t_fill_all();
      t_addr_latch();
      t_unmapped();
      t_abort();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule